// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block turns a reference clock of arbitrary frequency into an exact average one-microsecond rate and counts those microseconds in a free-running 32-bit register. The ratio is programmed as a pair of small integers: on every reference cycle a fractional accumulator adds the numerator, and each time the running sum reaches the denominator it emits one tick and subtracts the denominator. References that are not whole multiples of 1 MHz, such as 19.2 MHz, therefore still give 1 MHz on average and with no long-term drift.

Software reaches the block through a plain single-cycle register bus. A read returns the count, the ratio setting or the hold control. Writes can change the ratio, preset the count, or pause counting with a hold bit. Reads see the held value, and the fractional remainder is preserved while counting is paused. The count can serve as a monotonic clock and as a busy-wait delay reference.

Top module: `microTimebase`

## Requirements
- R1: After reset the count reads 0, the ratio register reads 0x000b and the hold register reads 0.
- R2: The ratio register sits at offset 0x14. Bits [15:8] hold numerator minus one and bits [7:0] hold denominator minus one. With a numerator smaller than the denominator, N accumulating cycles after the accumulator is cleared add floor(N*num/den) to the count. The settings 0x000b, 0x000c and 0x0019 give one tick per 12, 13 and 26 cycles.
- R3: The setting 0x045f (5/96) gives exactly 5 ticks per 96 cycles, which is 1 MHz from 19.2 MHz.
- R4: A write to the ratio register clears the accumulator in its own cycle and gives no tick in that cycle. The new ratio applies from the next cycle.
- R5: When the numerator is greater than or equal to the denominator, the count advances by one on every running cycle.
- R6: The hold register is at offset 0x4c, and only bit 0 is stored. While it is 1, the count and the accumulator hold their values. The cycle that writes it still uses the old setting, and clearing it resumes counting with the remainder it had.
- R7: A write to the count register at offset 0x10 loads the written value. The load wins over a tick in the same cycle, and counting continues from the loaded value.
- R8: The count is a 32-bit up-counter that wraps from 0xFFFFFFFF to 0. Apart from a load, it never changes by anything other than +1.
- R9: Reads of unmapped offsets return 0, and writes to them change nothing. The ratio register reads back only its low 16 bits, and the hold register reads back only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |

## Verification
Two functions can fall in the same reference cycle. A register write (to the ratio or to the count) can land on the cycle in which the accumulator would have produced a tick. The bench provokes this by selecting a one-tick-per-cycle ratio, so that every cycle is a tick cycle. It then writes the ratio or the count and reads the count right after that edge. The write must win: the count must be unchanged after a ratio write and must equal the loaded value after a count write. The accumulator clear is judged by running 11 cycles of a 1/12 ratio and rewriting it. No tick may then appear before 12 further cycles.

// File: rtl/mtbPkg.sv
package mtbPkg;
  // strobes from the register control to the datapath
  typedef struct packed {
    logic cfgWr;  // ratio write this cycle: clear the accumulator, no tick
    logic cntWr;  // count preset this cycle
    logic run;    // counting enabled (hold bit clear)
  } strobeT;
endpackage

// File: rtl/mtbCtrl.sv
module mtbCtrl
  import mtbPkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned HALF_W  = 8,
  parameter int unsigned CNT_OFF = 'h10,
  parameter int unsigned CFG_OFF = 'h14,
  parameter int unsigned FRZ_OFF = 'h4c,
  parameter int unsigned CFG_RST = 'h000b,
  localparam int unsigned CFG_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wrData,
  output logic [CFG_W-1:0]  cfgQ,
  output logic              freezeQ,
  output strobeT            strobe
);
  logic hitCfg, hitCnt, hitFrz;

  assign hitCfg = wrEn && (addr == ADDR_W'(CFG_OFF));
  assign hitCnt = wrEn && (addr == ADDR_W'(CNT_OFF));
  assign hitFrz = wrEn && (addr == ADDR_W'(FRZ_OFF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= CFG_W'(CFG_RST);
      freezeQ <= 1'b0;
    end else begin
      if (hitCfg) cfgQ <= wrData;
      if (hitFrz) freezeQ <= wrData[0];
    end
  end

  always_comb begin
    strobe.cfgWr = hitCfg;
    strobe.cntWr = hitCnt;
    strobe.run   = !freezeQ;
  end
endmodule

// File: rtl/mtbFracTick.sv
module mtbFracTick #(
  parameter int unsigned HALF_W = 8,
  localparam int unsigned ACC_W = HALF_W + 1,
  localparam int unsigned SUM_W = HALF_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALF_W-1:0] numM1,
  input  logic [HALF_W-1:0] denM1,
  input  logic              clr,
  input  logic              run,
  output logic              tick
);
  logic [ACC_W-1:0] num, den, accQ;
  logic [SUM_W-1:0] sum;
  logic             saturate, reach;

  assign num      = ACC_W'(numM1) + 1'b1;
  assign den      = ACC_W'(denM1) + 1'b1;
  assign sum      = SUM_W'(accQ) + SUM_W'(num);
  assign saturate = (num >= den);
  assign reach    = (sum >= SUM_W'(den));
  assign tick     = run && !clr && (saturate || reach);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (clr) begin
      accQ <= '0;
    end else if (run) begin
      if (saturate)   accQ <= '0;
      else if (reach) accQ <= ACC_W'(sum - SUM_W'(den));
      else            accQ <= ACC_W'(sum);
    end
  end
endmodule

// File: rtl/mtbCounter.sv
module mtbCounter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     countQ <= '0;
    else if (load) countQ <= loadVal;
    else if (tick) countQ <= countQ + 1'b1;
  end
endmodule

// File: rtl/microTimebase.sv
module microTimebase
  import mtbPkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned HALF_W  = 8,
  parameter int unsigned CNT_OFF = 'h10,
  parameter int unsigned CFG_OFF = 'h14,
  parameter int unsigned FRZ_OFF = 'h4c,
  parameter int unsigned CFG_RST = 'h000b
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int unsigned CFG_W = 2 * HALF_W;

  strobeT              strobe;
  logic [CFG_W-1:0]    cfgQ;
  logic                freezeQ;
  logic                tick;
  logic [DATA_W-1:0]   countQ;

  mtbCtrl #(
    .ADDR_W(ADDR_W), .HALF_W(HALF_W), .CNT_OFF(CNT_OFF),
    .CFG_OFF(CFG_OFF), .FRZ_OFF(FRZ_OFF), .CFG_RST(CFG_RST)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData[CFG_W-1:0]), .cfgQ(cfgQ), .freezeQ(freezeQ),
    .strobe(strobe)
  );

  mtbFracTick #(.HALF_W(HALF_W)) uFrac (
    .clk(clk), .rstN(rstN),
    .numM1(cfgQ[CFG_W-1:HALF_W]), .denM1(cfgQ[HALF_W-1:0]),
    .clr(strobe.cfgWr), .run(strobe.run), .tick(tick)
  );

  mtbCounter #(.CNT_W(DATA_W)) uCnt (
    .clk(clk), .rstN(rstN), .tick(tick), .load(strobe.cntWr),
    .loadVal(wrData), .countQ(countQ)
  );

  always_comb begin
    if (addr == ADDR_W'(CNT_OFF))      rdData = countQ;
    else if (addr == ADDR_W'(CFG_OFF)) rdData = DATA_W'(cfgQ);
    else if (addr == ADDR_W'(FRZ_OFF)) rdData = DATA_W'(freezeQ);
    else                               rdData = '0;
  end
endmodule

// File: rtl/mtbChecker.sv
module mtbChecker #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned HALF_W  = 8,
  parameter int unsigned CNT_OFF = 'h10,
  parameter int unsigned CFG_OFF = 'h14
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wrData,
  input logic [2*HALF_W-1:0] cfgQ,
  input logic                freezeQ,
  input logic [DATA_W-1:0]   countQ
);
  logic cntWrite, cfgWrite;
  assign cntWrite = wrEn && (addr == ADDR_W'(CNT_OFF));
  assign cfgWrite = wrEn && (addr == ADDR_W'(CFG_OFF));

  assert_cfg_write_no_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> $stable(countQ));

  assert_saturated_every_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !freezeQ && (cfgQ[2*HALF_W-1:HALF_W] >= cfgQ[HALF_W-1:0]))
      |=> (countQ == DATA_W'($past(countQ) + 1'b1)));

  assert_hold_keeps_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (freezeQ && !cntWrite) |=> $stable(countQ));

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |=> (countQ == $past(wrData)));

  assert_step_by_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cntWrite |=> ($stable(countQ) || (countQ == DATA_W'($past(countQ) + 1'b1))));
endmodule

bind microTimebase mtbChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W),
  .CNT_OFF(CNT_OFF), .CFG_OFF(CFG_OFF)
) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .cfgQ(cfgQ), .freezeQ(freezeQ), .countQ(countQ)
);

// File: tb/test_microTimebase.sv
module test_microTimebase;
  localparam logic [7:0] A_CNT = 8'h10;
  localparam logic [7:0] A_CFG = 8'h14;
  localparam logic [7:0] A_FRZ = 8'h4c;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  microTimebase i_microTimebase (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] expect_ticks(input logic [31:0] c0, input logic [15:0] cfg, input int n);
    longint num = longint'(cfg[15:8]) + 1;
    longint den = longint'(cfg[7:0]) + 1;
    longint add = (num >= den) ? longint'(n) : (longint'(n) * num) / den;
    return c0 + 32'(add);
  endfunction

  // clear the accumulator with a ratio write, run n cycles, compare
  task automatic runRatio(input logic [15:0] cfg, input int n, input string tag);
    logic [31:0] c0, v;
    readReg(A_CNT, c0);
    writeReg(A_CFG, {16'h0, cfg});
    readReg(A_CFG, v);
    check({tag, " ratio readback"}, v, {16'h0, cfg});
    idle(n);
    readReg(A_CNT, v);
    check({tag, " count after run"}, v, expect_ticks(c0, cfg, n));
  endtask

  task automatic testReset();
    logic [31:0] v;
    readReg(A_CNT, v); check("R1 count", v, 32'h0);
    readReg(A_CFG, v); check("R1 ratio", v, 32'h000b);
    readReg(A_FRZ, v); check("R1 hold", v, 32'h0);
  endtask

  task automatic testDefaultRate();
    logic [31:0] v;
    idle(37);
    readReg(A_CNT, v);
    check("R2 default 1/12 after 37 cycles", v, 32'd3);
  endtask

  task automatic testRatios();
    runRatio(16'h000c, 130, "R2 1/13");
    runRatio(16'h0019, 53, "R2 1/26");
    runRatio(16'h045f, 960, "R3 5/96 full");
    runRatio(16'h045f, 200, "R3 5/96 partial");
  endtask

  task automatic testCfgCollision();
    logic [31:0] c0, v;
    writeReg(A_CFG, 32'h0000);
    readReg(A_CNT, c0);
    writeReg(A_CFG, 32'h0000);
    readReg(A_CNT, v);
    check("R4 no tick on ratio write", v, c0);
    writeReg(A_CFG, 32'h000b);
    idle(11);
    readReg(A_CNT, c0);
    writeReg(A_CFG, 32'h000b);
    idle(11);
    readReg(A_CNT, v);
    check("R4 accumulator cleared", v, c0);
    idle(1);
    readReg(A_CNT, v);
    check("R4 tick after 12", v, c0 + 1);
  endtask

  task automatic testSaturate();
    runRatio(16'h0300, 20, "R5 num>den");
  endtask

  task automatic testHold();
    logic [31:0] c0, v;
    readReg(A_CNT, c0);
    writeReg(A_CFG, 32'h0001);      // 1/2
    idle(4);
    writeReg(A_FRZ, 32'hffff_ffff); // this edge still runs: 5 running
    readReg(A_FRZ, v); check("R6 hold reads 1", v, 32'h1);
    readReg(A_CNT, v); check("R6 count at hold", v, c0 + 2);
    idle(30);
    readReg(A_CNT, v); check("R6 count held", v, c0 + 2);
    writeReg(A_FRZ, 32'h0);         // this edge is still held
    readReg(A_CNT, v); check("R6 release edge held", v, c0 + 2);
    idle(1);
    readReg(A_CNT, v); check("R6 remainder kept", v, c0 + 3);
  endtask

  task automatic testLoadWrap();
    logic [31:0] v;
    writeReg(A_CFG, 32'h0000);
    writeReg(A_CNT, 32'h1234_5678);
    readReg(A_CNT, v); check("R7 load wins over tick", v, 32'h1234_5678);
    idle(1);
    readReg(A_CNT, v); check("R7 counts from load", v, 32'h1234_5679);
    writeReg(A_CNT, 32'hffff_fffe);
    idle(1);
    readReg(A_CNT, v); check("R8 reaches max", v, 32'hffff_ffff);
    idle(1);
    readReg(A_CNT, v); check("R8 wraps to zero", v, 32'h0);
  endtask

  task automatic testDecode();
    logic [31:0] v;
    writeReg(A_FRZ, 32'h1);
    writeReg(A_CNT, 32'h0000_00aa);
    writeReg(8'h20, 32'hffff_ffff);
    writeReg(8'h00, 32'h5555_5555);
    readReg(8'h20, v); check("R9 unmapped reads 0", v, 32'h0);
    readReg(A_CNT, v); check("R9 unmapped write leaves count", v, 32'h0000_00aa);
    readReg(A_CFG, v); check("R9 unmapped write leaves ratio", v, 32'h0000);
    readReg(A_FRZ, v); check("R9 unmapped write leaves hold", v, 32'h1);
    writeReg(A_CFG, 32'habcd_1234);
    readReg(A_CFG, v); check("R9 ratio low 16 bits", v, 32'h0000_1234);
    writeReg(A_FRZ, 32'h0);
    runRatio(16'h1234, 106, "R2 19/53");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDefaultRate();
    testRatios();
    testCfgCollision();
    testSaturate();
    testHold();
    testLoadWrap();
    testDecode();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule